// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

This block raises a message to an exponent modulo an odd modulus, `result = M^E mod N`, for a `W`-bit modulus (default 32). It scans the exponent from its top bit down, squaring for each bit and multiplying again when the bit is set. Every multiplication is a bit-serial radix-2 Montgomery product. That product keeps its partial sum in carry-save form and runs `W+2` reduction steps, so residues stay below `2N` and no subtraction step is needed between multiplications.

Software loads four operands one byte at a time through a shared byte port with a two-bit select code: the message, the exponent, the modulus and the conversion constant `2^(2W+4) mod N`. On start, the engine shifts the exponent left until its top bit is set and counts its significant bits. It then converts the message into the Montgomery domain and runs the square/multiply sequence. A last product by the constant 1 removes the Montgomery factor and brings the value into the range `[0, N]`. A one-cycle `done` pulse marks the end of the run. The result is held until the next run completes.

Top module: `mont_modexp`

## Requirements
- R1: Operands load MSB-first, one byte per cycle with `ld_valid` high, `W/8` bytes each. Select code 0 loads the message, 1 the exponent, 2 the modulus and 3 the constant `2^(2W+4) mod N`. Loads presented while `busy` is high are ignored.
- R2: `start` while idle begins a run, and `busy` is high from the next cycle until the cycle that `done` is high. A `start` while busy has no effect on the run's result or length.
- R3: For odd `N >= 3`, `1 <= M < N`, any exponent and the correct constant, `result` equals `M^E mod N`.
- R4: A zero exponent gives `result = 1` with `done` high one cycle after the start edge, and no multiplication runs.
- R5: Exponent normalization takes `z+1` cycles, where `z` is the exponent's count of leading zeros. Each Montgomery product takes `W+4` cycles (one setup, `W+2` steps, one write-back).
- R6: A nonzero exponent with `L` significant bits and `P` set bits runs `L+P-2` loop products plus one conversion product and one final product. The total latency from the start edge to `done` is therefore `z+1+(L+P)*(W+4)` cycles.
- R7: `done` is high for exactly one cycle, `result` changes only in that cycle, and `result` never exceeds `N`.
- R8: A run consumes the message and exponent registers. The modulus and constant are kept, so a later run needs only a new message and exponent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load byte strobe |
| ld_sel | input | 2 | Operand select: 0 message, 1 exponent, 2 modulus, 3 constant |
| ld_byte | input | 8 | Load byte, most significant byte first |
| start | input | 1 | Begin an exponentiation |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Final residue, held between runs |

## Verification
The only result that is not at a fixed cycle is `done`. Its cycle is fixed by the exponent: one cycle after the start edge for a zero exponent, otherwise `z+1+(L+P)*(W+4)` cycles. The bench counts every clock edge from the start edge to the `done` pulse and compares that count with the value computed from the exponent. This checks normalization and the product count directly.

Inputs are driven on the falling edge and outputs are read on the falling edge that follows each rising edge. `result` is compared against a reference square-and-multiply function in the cycle where `done` is seen. It is compared again one cycle later, when `done` must be low and `result` must not have moved.

// File: rtl/mont_modexp.sv
module mont_modexp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_valid,
  input  logic [1:0]   ld_sel,
  input  logic [7:0]   ld_byte,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int SW = W + 3;
  localparam int CW = $clog2(W + 3);
  localparam logic [CW-1:0] ITER = CW'(W + 2);
  localparam logic [1:0] P_CONV = 2'd0, P_SQ = 2'd1, P_MUL = 2'd2, P_POST = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_NORM, S_LOAD, S_RUN, S_WB} st_t;
  st_t st;

  logic [W:0]    msg_q, acc_q, a_sr, b_q;
  logic [W-1:0]  exp_q, mod_q, r2_q, res_q;
  logic [SW-1:0] s_q, c_q;
  logic [CW-1:0] cnt, rem;
  logic [1:0]    ph;
  logic          done_q;

  logic [SW-1:0] ab, s1, c1, qn, s2, c2, sum;
  logic [W:0]    val;
  logic [1:0]    ph_adv;

  assign ab  = a_sr[0] ? {2'b0, b_q} : '0;
  assign s1  = s_q ^ c_q ^ ab;
  assign c1  = ((s_q & c_q) | (s_q & ab) | (c_q & ab)) << 1;
  assign qn  = s1[0] ? {3'b0, mod_q} : '0;
  assign s2  = s1 ^ c1 ^ qn;
  assign c2  = ((s1 & c1) | (s1 & qn) | (c1 & qn)) << 1;
  assign sum = s_q + c_q;
  assign val = sum[W:0];
  assign ph_adv = (rem == CW'(1)) ? P_POST : P_SQ;

  assign busy   = (st != S_IDLE);
  assign done   = done_q;
  assign result = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_CONV; done_q <= 1'b0;
      msg_q <= '0; acc_q <= '0; a_sr <= '0; b_q <= '0;
      exp_q <= '0; mod_q <= '0; r2_q <= '0; res_q <= '0;
      s_q <= '0; c_q <= '0; cnt <= '0; rem <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ld_valid) begin
            case (ld_sel)
              2'd0: msg_q <= {1'b0, msg_q[W-9:0], ld_byte};
              2'd1: exp_q <= {exp_q[W-9:0], ld_byte};
              2'd2: mod_q <= {mod_q[W-9:0], ld_byte};
              default: r2_q <= {r2_q[W-9:0], ld_byte};
            endcase
          end
          if (start) begin
            st  <= S_NORM;
            rem <= CW'(W);
          end
        end
        S_NORM: begin
          if (exp_q == '0) begin
            res_q  <= W'(1);
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (exp_q[W-1]) begin
            ph <= P_CONV;
            st <= S_LOAD;
          end else begin
            exp_q <= exp_q << 1;
            rem   <= rem - 1'b1;
          end
        end
        S_LOAD: begin
          s_q <= '0; c_q <= '0; cnt <= ITER;
          case (ph)
            P_CONV:  begin a_sr <= msg_q; b_q <= {1'b0, r2_q}; end
            P_SQ:    begin a_sr <= acc_q; b_q <= acc_q; end
            P_MUL:   begin a_sr <= acc_q; b_q <= msg_q; end
            default: begin a_sr <= acc_q; b_q <= (W+1)'(1); end
          endcase
          st <= S_RUN;
        end
        S_RUN: begin
          s_q  <= s2 >> 1;
          c_q  <= c2 >> 1;
          a_sr <= a_sr >> 1;
          cnt  <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_WB;
        end
        S_WB: begin
          st <= S_LOAD;
          case (ph)
            P_CONV: begin
              msg_q <= val; acc_q <= val;
              exp_q <= exp_q << 1; rem <= rem - 1'b1; ph <= ph_adv;
            end
            P_SQ: begin
              acc_q <= val;
              if (exp_q[W-1]) ph <= P_MUL;
              else begin
                exp_q <= exp_q << 1; rem <= rem - 1'b1; ph <= ph_adv;
              end
            end
            P_MUL: begin
              acc_q <= val;
              exp_q <= exp_q << 1; rem <= rem - 1'b1; ph <= ph_adv;
            end
            default: begin
              res_q  <= val[W-1:0];
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_norm_lead_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && ph == P_CONV) |-> exp_q[W-1]);
  assert_product_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB) |-> (sum < ({3'b0, mod_q} << 1)));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_result_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result <= mod_q));
  assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(mod_q) && $stable(r2_q)));
endmodule

// File: tb/mont_modexp_bench.sv
module mont_modexp_bench;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, start = 1'b0;
  logic [1:0] ld_sel = '0;
  logic [7:0] ld_byte = '0;
  logic busy, done;
  logic [W-1:0] result;
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  mont_modexp #(.W(W)) u_mont_modexp (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .ld_byte(ld_byte), .start(start), .busy(busy), .done(done), .result(result));

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [W-1:0] ref_pow(input logic [W-1:0] m, e, n);
    logic [63:0] r = 64'd1 % n, b = m % n;
    for (int i = W - 1; i >= 0; i--) begin
      r = (r * r) % n;
      if (e[i]) r = (r * b) % n;
    end
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] conv_const(input logic [W-1:0] n);
    logic [63:0] v = 64'd1;
    repeat (2 * W + 4) v = (v << 1) % n;
    return v[W-1:0];
  endfunction

  function automatic int exp_cycles(input logic [W-1:0] e);
    int z = 0;
    if (e == '0) return 1;
    for (int i = W - 1; i >= 0 && !e[i]; i--) z++;
    return z + 1 + (W - z + $countones(e)) * (W + 4);
  endfunction

  task automatic load(input logic [1:0] sel, input logic [W-1:0] v);
    for (int i = W / 8 - 1; i >= 0; i--) begin
      ld_valid = 1'b1; ld_sel = sel; ld_byte = v[i*8 +: 8];
      @(negedge clk);
    end
    ld_valid = 1'b0;
  endtask

  task automatic set_mod(input logic [W-1:0] n);
    load(2'd2, n);
    load(2'd3, conv_const(n));
  endtask

  task automatic run(input logic [W-1:0] m, e, n, input bit inj, input string tag);
    int cyc = 0;
    logic [W-1:0] held;
    load(2'd0, m);
    load(2'd1, e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    while (1) begin
      @(negedge clk);
      cyc++;
      if (inj && cyc == 10) begin
        start = 1'b1; ld_valid = 1'b1; ld_sel = 2'd2; ld_byte = 8'h5A;
      end
      if (inj && cyc == 11) begin
        start = 1'b0; ld_valid = 1'b0;
      end
      if (done) break;
    end
    chk(result == ref_pow(m, e, n), {tag, " R3 result"}, result, ref_pow(m, e, n));
    chk(cyc == exp_cycles(e), {tag, " R6 latency"}, cyc, exp_cycles(e));
    chk(busy === 1'b0, {tag, " R2 idle at done"}, busy, 0);
    held = result;
    @(negedge clk);
    chk(done === 1'b0 && result == held, {tag, " R7 pulse/hold"}, result, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] n, m, e;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R2 reset idle", busy, 0);
    chk(result == '0, "R7 reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    n = 32'hFFFF_FFFB;
    set_mod(n);
    run(32'd2, 32'd0, n, 1'b0, "R4 zero exponent");
    run(32'd5, 32'd1, n, 1'b0, "R5 unit exponent");
    run(32'd7, 32'h0000_0100, n, 1'b0, "R5 leading zeros");
    run(32'd3, 32'hFFFF_FFFF, n, 1'b0, "R6 all ones");
    run(n - 1, 32'd2, n, 1'b0, "R3 minus one squared");
    run(32'h1234_5678, 32'h8000_0000, n, 1'b0, "R6 top bit only");
    run(32'h0BAD_F00D, 32'h0001_0001, n, 1'b1, "R1 R2 injected during run");
    run(32'd11, 32'd65537, n, 1'b0, "R8 modulus kept");

    n = 32'd3;
    set_mod(n);
    run(32'd2, 32'd3, n, 1'b0, "R3 smallest modulus");
    run(32'd1, 32'hDEAD_BEEF, n, 1'b0, "R8 unit message");

    for (int k = 0; k < 20; k++) begin
      n = $urandom | 32'h1;
      if (n < 32'd3) n = 32'd3;
      m = $urandom % n;
      if (m == '0) m = 32'd1;
      e = $urandom >> ($urandom % 32);
      set_mod(n);
      run(m, e, n, (k % 5) == 0, "R3 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule